// File: doc/BRIEF.md
# Dual-Output PWM Compare Generator

This block turns the count of an external PWM timebase into two independent pulse-width-modulated pins, A and B. Each pin has its own compare timestamp. Software writes the timestamp into a shadow register. The value moves into the working compare register only when the timebase flags its zero point, so a period never runs with a mix of old and new settings.

Each pin applies one of two compare rules. The edge rule is used for single-direction counting and drives the pin active while the count is below the timestamp. The center rule is used for up-down counting and drives the pin active while the count is at or above a non-zero timestamp, which gives a pulse centered on the count peak. Polarity can be set per pin. A per-pin override forces the pin to a level chosen by software, whatever the timebase is doing.

The pins are registered. A pin shows, one clock later, the result for the inputs sampled at a clock edge. The timebase itself, meaning the counter, the period and the prescaler, is outside this block.

Top module: `pwm_cmp_gen`

## Requirements
- R1: After reset both pins are low and both working timestamps are 0, so with no override and polarity 0 the pins stay low until a zero point loads a shadow value.
- R2: With `sym_en`=0, polarity 0 and no override, a pin is high exactly when `tb_cnt` is less than its working timestamp. When counting up, this means high from count 0 and low from the count equal to the timestamp.
- R3: With `sym_en`=0, a timestamp of 0 gives a pin that is inactive all the time. A timestamp larger than the highest count reached gives a pin that is active all the time.
- R4: When counting up through 0..99 with timestamp 50, polarity 0 and no override, a pin is high for exactly 50 of every 100 clocks.
- R5: With `sym_en`=1, a pin is active exactly when its working timestamp is non-zero and `tb_cnt` is greater than or equal to it. It therefore turns on as the up-count reaches the timestamp and turns off once the down-count drops below it.
- R6: A write pulse (`shd_wr_x`=1) stores `shd_val_x` in the shadow register only. In a clock with `tb_zero`=1, the compare uses the shadow value and then keeps it as the working timestamp until the next zero point. A write made between zero points has no effect on the running period.
- R7: Polarity 1 inverts the compare result on the pin. Polarity 0 passes it through.
- R8: While `ovr_en_x`=1, the pin equals the `ovr_lvl_x` sampled at the previous clock, regardless of count, timestamp and polarity.
- R9: After `ovr_en_x` is cleared, the pin follows the compare result again from the next clock on.
- R10: The pins are registered. An input change has no effect on a pin until the next rising clock edge.
- R11: Pins A and B are independent. Timestamp, polarity and override of one pin never affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tb_cnt | input | CNT_W | Current timebase count |
| tb_zero | input | 1 | Timebase is at its zero point this clock |
| sym_en | input | 1 | 0: edge compare rule, 1: center compare rule |
| shd_wr_a | input | 1 | Write strobe for the shadow timestamp of pin A |
| shd_val_a | input | CNT_W | New shadow timestamp for pin A |
| pol_a | input | 1 | Pin A polarity, 1 inverts |
| ovr_en_a | input | 1 | Override enable for pin A |
| ovr_lvl_a | input | 1 | Forced level of pin A |
| shd_wr_b | input | 1 | Write strobe for the shadow timestamp of pin B |
| shd_val_b | input | CNT_W | New shadow timestamp for pin B |
| pol_b | input | 1 | Pin B polarity, 1 inverts |
| ovr_en_b | input | 1 | Override enable for pin B |
| ovr_lvl_b | input | 1 | Forced level of pin B |
| pwm_a | output | 1 | PWM pin A |
| pwm_b | output | 1 | PWM pin B |

## Verification
The compare rules are swept over a short period of 7 with every timestamp from 0 to 9. The sweep covers up counting, down counting and up-down counting, each with both polarities. This separates the below-timestamp rule from the at-or-above rule and exercises the constant-level ends at 0 and beyond the period. Pin B always runs the mirrored timestamp with the opposite polarity, so any leakage between pins shows up. Further runs check the following:
- A shadow write in the middle of a period, which must stay invisible until the next zero point.
- Override pulses at counts where the compare would give the opposite level.
- A full 100-count period that measures the 50 % duty.

// File: rtl/pwm_cmp_pkg.sv
// Package: shared types for the dual-output PWM compare generator.
// Assumes nothing beyond a single clock domain.
package pwm_cmp_pkg;

    // Number of PWM pins per generator.
    localparam int NUM_PINS = 2;

    // Per-pin output stage configuration.
    typedef struct packed {
        logic ovr_en;   // force the pin
        logic ovr_lvl;  // forced level
        logic pol;      // 1 inverts compare result
    } pin_cfg_t;

endpackage

// File: rtl/pwm_ts_shadow.sv
// Module: shadowed compare timestamp.
// Holds a software-written shadow value and a working value. The working
// value is refreshed from the shadow at every timebase zero point.
// Assumes tb_zero is a single-clock pulse from the timebase.
module pwm_ts_shadow #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wval,
    input  logic             zero,
    output logic [CNT_W-1:0] eff_ts
);
    logic [CNT_W-1:0] shd_q;
    logic [CNT_W-1:0] act_q;

    // Shadow register: captures software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)  shd_q <= '0;
        else if (wr) shd_q <= wval;
    end

    // Working register: loads the shadow at the zero point.
    always_ff @(posedge clk) begin
        if (!rst_n)    act_q <= '0;
        else if (zero) act_q <= shd_q;
    end

    // Timestamp in force this clock: the zero tick already uses the new value.
    always_comb eff_ts = zero ? shd_q : act_q;

endmodule

// File: rtl/pwm_cmp_rule.sv
// Module: compare rule producing the raw active level of one pin.
// Edge rule (sym=0): active while count < timestamp.
// Center rule (sym=1): active while timestamp != 0 and count >= timestamp.
// Purely combinational; assumes count and timestamp share a width.
module pwm_cmp_rule #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] ts,
    input  logic             sym,
    output logic             active
);
    logic ts_nz;

    // Select the rule for the current counting scheme.
    always_comb begin
        ts_nz = |ts;
        if (sym) active = ts_nz && (cnt >= ts);
        else     active = (cnt < ts);
    end

endmodule

// File: rtl/pwm_pin_drv.sv
// Module: output stage of one pin. Applies polarity, then the override,
// and registers the result. Assumes the override is meant to act on the
// next clock whatever the timebase phase.
module pwm_pin_drv
    import pwm_cmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     active,
    input  pin_cfg_t cfg,
    output logic     pin
);
    logic pin_d;

    // Choose forced level or polarity-adjusted compare result.
    always_comb pin_d = cfg.ovr_en ? cfg.ovr_lvl : (active ^ cfg.pol);

    // Output register: glitch-free pin.
    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else        pin <= pin_d;
    end

endmodule

// File: rtl/pwm_cmp_gen.sv
// Module: dual-output PWM compare generator (top).
// Consumes the count and zero pulse of an external timebase and drives two
// independent PWM pins, each with a shadowed timestamp, polarity and
// software override. Assumes tb_zero is high exactly in the clock where
// the timebase count is at its zero point.
module pwm_cmp_gen
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tb_cnt,
    input  logic             tb_zero,
    input  logic             sym_en,
    input  logic             shd_wr_a,
    input  logic [CNT_W-1:0] shd_val_a,
    input  logic             pol_a,
    input  logic             ovr_en_a,
    input  logic             ovr_lvl_a,
    input  logic             shd_wr_b,
    input  logic [CNT_W-1:0] shd_val_b,
    input  logic             pol_b,
    input  logic             ovr_en_b,
    input  logic             ovr_lvl_b,
    output logic             pwm_a,
    output logic             pwm_b
);
    logic [NUM_PINS-1:0]            wr_v;
    logic [NUM_PINS-1:0][CNT_W-1:0] wval_v;
    logic [NUM_PINS-1:0][CNT_W-1:0] ts_v;
    logic [NUM_PINS-1:0]            act_v;
    logic [NUM_PINS-1:0]            pin_v;
    pin_cfg_t [NUM_PINS-1:0]        cfg_v;

    // Gather per-pin controls into vectors, A at index 0.
    always_comb begin
        wr_v   = {shd_wr_b, shd_wr_a};
        wval_v = {shd_val_b, shd_val_a};
        cfg_v[0] = '{ovr_en: ovr_en_a, ovr_lvl: ovr_lvl_a, pol: pol_a};
        cfg_v[1] = '{ovr_en: ovr_en_b, ovr_lvl: ovr_lvl_b, pol: pol_b};
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        pwm_ts_shadow #(.CNT_W(CNT_W)) u_shadow (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr_v[g]),
            .wval  (wval_v[g]),
            .zero  (tb_zero),
            .eff_ts(ts_v[g])
        );

        pwm_cmp_rule #(.CNT_W(CNT_W)) u_rule (
            .cnt   (tb_cnt),
            .ts    (ts_v[g]),
            .sym   (sym_en),
            .active(act_v[g])
        );

        pwm_pin_drv u_drv (
            .clk   (clk),
            .rst_n (rst_n),
            .active(act_v[g]),
            .cfg   (cfg_v[g]),
            .pin   (pin_v[g])
        );
    end

    // Map pin vector onto named outputs.
    always_comb begin
        pwm_a = pin_v[0];
        pwm_b = pin_v[1];
    end

endmodule

// File: rtl/pwm_cmp_gen_chk.sv
// Checker: temporal properties of pwm_cmp_gen at its ports, bound below.
// Keeps its own image of the pin A shadow register, built from the write port.
module pwm_cmp_gen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] tb_cnt,
    input logic             tb_zero,
    input logic             sym_en,
    input logic             shd_wr_a,
    input logic [CNT_W-1:0] shd_val_a,
    input logic             pol_a,
    input logic             ovr_en_a,
    input logic             ovr_lvl_a,
    input logic             ovr_en_b,
    input logic             ovr_lvl_b,
    input logic             pwm_a,
    input logic             pwm_b
);
    logic [CNT_W-1:0] shd_img;

    // Image of the pin A shadow value as written through the port.
    always_ff @(posedge clk) begin
        if (!rst_n)        shd_img <= '0;
        else if (shd_wr_a) shd_img <= shd_val_a;
    end

    AST_OVR_FORCE_A: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en_a |=> (pwm_a == $past(ovr_lvl_a)));                          // R8
    AST_OVR_FORCE_B: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en_b |=> (pwm_b == $past(ovr_lvl_b)));                          // R11
    AST_ZERO_LOADS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_zero && tb_cnt == '0 && !sym_en && !ovr_en_a && !pol_a && shd_img != '0)
        |=> pwm_a);                                                         // R6
    AST_ZERO_TS_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_zero && !sym_en && !ovr_en_a && !pol_a && shd_img == '0)
        |=> !pwm_a);                                                        // R3
    AST_CENTER_VALLEY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_en && tb_cnt == '0 && !ovr_en_a && !pol_a) |=> !pwm_a);        // R5

endmodule

bind pwm_cmp_gen pwm_cmp_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tb_cnt   (tb_cnt),
    .tb_zero  (tb_zero),
    .sym_en   (sym_en),
    .shd_wr_a (shd_wr_a),
    .shd_val_a(shd_val_a),
    .pol_a    (pol_a),
    .ovr_en_a (ovr_en_a),
    .ovr_lvl_a(ovr_lvl_a),
    .ovr_en_b (ovr_en_b),
    .ovr_lvl_b(ovr_lvl_b),
    .pwm_a    (pwm_a),
    .pwm_b    (pwm_b)
);

// File: tb/pwm_cmp_gen_bench.sv
// Bench: sweeps timestamps, counting schemes and polarities; expectations come
// from the requirement formulas in an independent per-pin model.
module pwm_cmp_gen_bench;
    localparam int CW = 16;
    localparam int SP = 7;   // sweep period (highest count)

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] tb_cnt = '0;
    logic          tb_zero = 1'b0;
    logic          sym_en = 1'b0;
    logic          shd_wr_a = 1'b0, shd_wr_b = 1'b0;
    logic [CW-1:0] shd_val_a = '0, shd_val_b = '0;
    logic          pol_a = 1'b0, pol_b = 1'b0;
    logic          ovr_en_a = 1'b0, ovr_en_b = 1'b0;
    logic          ovr_lvl_a = 1'b0, ovr_lvl_b = 1'b0;
    logic          pwm_a, pwm_b;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // model state, index 0 = A, 1 = B
    int m_shd [2];
    int m_act [2];

    pwm_cmp_gen #(.CNT_W(CW)) u_pwm_cmp_gen (
        .clk(clk), .rst_n(rst_n), .tb_cnt(tb_cnt), .tb_zero(tb_zero),
        .sym_en(sym_en),
        .shd_wr_a(shd_wr_a), .shd_val_a(shd_val_a), .pol_a(pol_a),
        .ovr_en_a(ovr_en_a), .ovr_lvl_a(ovr_lvl_a),
        .shd_wr_b(shd_wr_b), .shd_val_b(shd_val_b), .pol_b(pol_b),
        .ovr_en_b(ovr_en_b), .ovr_lvl_b(ovr_lvl_b),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b at t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic rule(input int cnt, input int ts, input logic sym);
        if (sym) return (ts != 0) && (cnt >= ts);
        return cnt < ts;
    endfunction

    // One clock: predict, update model, clock, compare.
    task automatic step(input string tag_a, input string tag_b);
        int eff_a, eff_b;
        logic ea, eb;
        eff_a = tb_zero ? m_shd[0] : m_act[0];
        eff_b = tb_zero ? m_shd[1] : m_act[1];
        ea = ovr_en_a ? ovr_lvl_a : (rule(int'(tb_cnt), eff_a, sym_en) ^ pol_a);
        eb = ovr_en_b ? ovr_lvl_b : (rule(int'(tb_cnt), eff_b, sym_en) ^ pol_b);
        if (tb_zero) begin m_act[0] = m_shd[0]; m_act[1] = m_shd[1]; end
        if (shd_wr_a) m_shd[0] = int'(shd_val_a);
        if (shd_wr_b) m_shd[1] = int'(shd_val_b);
        @(posedge clk); #1;
        check(tag_a, pwm_a, ea);
        check(tag_b, pwm_b, eb);
    endtask

    task automatic drive_cnt(input int c);
        tb_cnt = CW'(c);
        tb_zero = (c == 0);
    endtask

    task automatic write_ts(input int ta, input int tb);
        drive_cnt(1);
        shd_wr_a = 1'b1; shd_val_a = CW'(ta);
        shd_wr_b = 1'b1; shd_val_b = CW'(tb);
        step("R6 write", "R6 write B");
        shd_wr_a = 1'b0; shd_wr_b = 1'b0;
    endtask

    // mode 0 = up, 1 = down, 2 = up-down
    task automatic run_mode(input int mode, input int per, input string ta, input string tb);
        for (int r = 0; r < 2; r++) begin
            if (mode == 0) begin
                for (int c = 0; c <= per; c++) begin drive_cnt(c); step(ta, tb); end
            end else if (mode == 1) begin
                if (r == 0) begin drive_cnt(0); step(ta, tb); end
                for (int c = per; c >= 0; c--) begin drive_cnt(c); step(ta, tb); end
            end else begin
                for (int c = 0; c <= per; c++) begin drive_cnt(c); step(ta, tb); end
                for (int c = per - 1; c >= 1; c--) begin drive_cnt(c); step(ta, tb); end
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int highs;
        string ta, tb;
        m_shd = '{0, 0};
        m_act = '{0, 0};
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset pin A", pwm_a, 1'b0);
        check("R1 reset pin B", pwm_b, 1'b0);
        rst_n = 1'b1;
        drive_cnt(3);
        step("R1 working ts 0 A", "R1 working ts 0 B");

        // R10: change waits for the edge
        ovr_en_a = 1'b1; ovr_lvl_a = 1'b1;
        #1;
        check("R10 no change before edge", pwm_a, 1'b0);
        step("R10 override after edge", "R11 B untouched");
        ovr_en_a = 1'b0; ovr_lvl_a = 1'b0;
        step("R9 release", "R11 B untouched");

        // sweep timestamps x modes x polarity; B mirrored, opposite polarity
        for (int mode = 0; mode < 3; mode++) begin
            for (int p = 0; p < 2; p++) begin
                for (int ts = 0; ts <= SP + 2; ts++) begin
                    sym_en = (mode == 2);
                    pol_a = p[0]; pol_b = ~p[0];
                    write_ts(ts, SP + 2 - ts);
                    if (mode == 2)                ta = "R5";
                    else if (ts == 0 || ts > SP)  ta = "R3";
                    else                          ta = "R2";
                    if (p != 0) ta = {ta, " R7"};
                    tb = {"R11 ", ta};
                    run_mode(mode, SP, ta, tb);
                end
            end
        end
        sym_en = 1'b0; pol_a = 1'b0; pol_b = 1'b0;

        // R6: mid-period write must not disturb the running period
        write_ts(2, 5);
        for (int c = 0; c <= SP; c++) begin
            drive_cnt(c);
            if (c == 1) begin
                shd_wr_a = 1'b1; shd_val_a = CW'(6);
            end
            step("R6 mid-period write A", "R11 B");
            shd_wr_a = 1'b0;
        end
        drive_cnt(0);
        step("R6 applied at zero", "R11 B");
        drive_cnt(5);
        step("R6 new ts in force", "R11 B");
        check("R6 count 5 below new ts 6", pwm_a, 1'b1);

        // R8/R9: override against compare, toggling level
        run_mode(0, SP, "R2", "R11");
        for (int c = 0; c <= SP; c++) begin
            drive_cnt(c);
            ovr_en_a = (c >= 2 && c <= 5);
            ovr_lvl_a = c[0];
            pol_a = (c == 4);
            step((c >= 2 && c <= 5) ? "R8 override" : "R9 compare", "R11 B");
        end
        ovr_en_a = 1'b0;
        ovr_en_b = 1'b1; ovr_lvl_b = 1'b1;
        drive_cnt(0);
        step("R11 A unaffected", "R8 override B");
        ovr_en_b = 1'b0;
        pol_a = 1'b0;

        // R4: period 99, timestamp 50 -> 50 of 100 high
        write_ts(50, 0);
        drive_cnt(0);
        step("R4 pre", "R4 pre B");
        for (int c = 1; c <= 99; c++) begin drive_cnt(c); step("R4", "R4 B"); end
        highs = 0;
        for (int c = 0; c <= 99; c++) begin
            drive_cnt(c);
            step("R4", "R4 B");
            if (pwm_a) highs++;
        end
        n_checks++;
        if (highs != 50) begin
            n_errors++;
            $display("FAIL R4 duty: got %0d expected 50", highs);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule